// File: doc/BRIEF.md
# Flash Memory Command Sequencer

This block is a register-driven sequencer for a small nonvolatile word array. Software loads an address register, a data register and a mode register, then writes a 4-bit code into the command register. The sequencer checks the command against the write-enable bit, the page protection mask and the mass-erase unlock key. It then either rejects it at once or goes busy for a command-specific number of clock cycles, plus the programmed wait states. At the end of the busy period it applies the command's effect to the array and sets the status register. If enabled, it also raises a one-cycle completion interrupt.

The array is a behavioural register file of 16-bit words that erases to 0xFFFF. It is split into equal pages, and the lowest words form a kernel region that mass erase leaves alone. Durations are parameters counted in clock cycles, which keeps runs short. The signature command folds every word into a CRC-24 while it is busy.

Top module: `flash_cmd_seq`

## Requirements
- R1: The register offsets are: 0 command, 1 address, 2 data, 3 mode, 4 status, 5 signature bits [15:0], 6 signature bits [23:16], 7 protection mask. After reset every array word reads 0xFFFF. The command, status, mode and signature registers read 0, and `irq` is low.
- R2: An accepted command keeps the command register reading 0x0007 for exactly base + W cycles, where W is mode bits [1:0], and afterwards it reads 0. The default base cycles are: read 2, write 3, erase-then-write 20, verify 2, page erase 10, mass erase 30, signature 32 (one per word), protect 2, ping 1.
- R3: The mode register keeps only bit 4 (interrupt enable), bit 3 (erase/write enable) and bits [1:0] (wait states). Bits 2 and [7:5] always read 0.
- R4: With mode bit 3 clear, codes 0x2, 0x3, 0x5 and 0x6 are rejected. A rejected command never goes busy, leaves the array unchanged and sets status to 0b100. Status bit 0 means completed, bit 1 means verify matched, and bit 2 means rejected.
- R5: Pages are aligned groups of 8 words. Code 0x1 loads the addressed word into the data register. Code 0x2 writes the data register to the addressed word. Code 0x5 erases the addressed page to 0xFFFF. Code 0x3 erases the page and then writes the word. Each completed command sets status to 0b001.
- R6: Code 0x4 sets status bit 1 exactly when the addressed word equals the data register.
- R7: Code 0x6 runs when the two data-register writes 0xA5C3 then 0x3C5A are immediately followed by the command write. It erases every word from address 8 upward, keeps words 0 to 7, and clears the protection mask and the protect-used flag.
- R8: Code 0x6 is rejected (status 0b100) when the key is missing, in the wrong order, or split by any other register write.
- R9: Code 0xB sets the 24-bit signature to a CRC-24 over all words in ascending address order, each word fed MSB first. The polynomial is 0x864CFB, the initial value 0xB704CE, with no reflection and no final XOR.
- R10: Code 0xC copies the value written at offset 7 into the active per-page protection mask (bit n guards page n), and it may do so only once. A second protect command is rejected. Codes 0x2, 0x3 and 0x5 that target a protected page are rejected.
- R11: When mode bit 4 is set, `irq` is high for exactly one cycle after each completed command, including ping (0xF). When bit 4 is clear, it stays low.
- R12: While busy, all register writes are ignored. Code 0x0 does nothing. Reserved codes (0x7 to 0xA, 0xD, 0xE) are rejected with status 0b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The embedded assertions watch, on every cycle, the properties that hold at all times:
- the busy counter stays within the loaded length;
- the array is never modified while erase/write is disabled;
- the kernel words hold across a mass erase;
- the reserved mode bits stay clear;
- the interrupt is a single-cycle pulse that follows a busy period;
- the unlock key only arms after its second value;
- the protection mask holds once used.

The bench scenarios show what needs history and a reference model: exact busy lengths with wait states, the data contents after write, erase and mass erase, the verify outcome, the CRC-24 signature value, the rejection of broken key sequences and of a second protect, and the writes ignored during busy.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [3:0] OP_NULL   = 4'h0;
  localparam logic [3:0] OP_READ   = 4'h1;
  localparam logic [3:0] OP_WRITE  = 4'h2;
  localparam logic [3:0] OP_ERWR   = 4'h3;
  localparam logic [3:0] OP_VERIFY = 4'h4;
  localparam logic [3:0] OP_ERASE  = 4'h5;
  localparam logic [3:0] OP_MASS   = 4'h6;
  localparam logic [3:0] OP_SIGN   = 4'hB;
  localparam logic [3:0] OP_PROT   = 4'hC;
  localparam logic [3:0] OP_PING   = 4'hF;

  localparam logic [2:0] RA_CMD    = 3'd0;
  localparam logic [2:0] RA_ADDR   = 3'd1;
  localparam logic [2:0] RA_DATA   = 3'd2;
  localparam logic [2:0] RA_MODE   = 3'd3;
  localparam logic [2:0] RA_STAT   = 3'd4;
  localparam logic [2:0] RA_SIGLO  = 3'd5;
  localparam logic [2:0] RA_SIGHI  = 3'd6;
  localparam logic [2:0] RA_PROT   = 3'd7;

  localparam logic [7:0]  MODE_KEEP = 8'h1B;
  localparam logic [15:0] BUSY_CODE = 16'h0007;
  localparam logic [23:0] CRC_POLY  = 24'h864CFB;
  localparam logic [23:0] CRC_SEED  = 24'hB704CE;

  typedef enum logic [2:0] {
    ARR_NONE, ARR_WRITE, ARR_PAGE, ARR_PAGE_WRITE, ARR_MASS
  } arr_op_e;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_st_e;

  function automatic logic [23:0] crc24_word(input logic [23:0] c, input logic [15:0] w);
    logic [23:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[23] ^ w[i]) r = {r[22:0], 1'b0} ^ CRC_POLY;
      else              r = {r[22:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_array.sv
module fcs_array
  import fcs_pkg::*;
#(
  parameter int WORDS        = 32,
  parameter int PAGE_WORDS   = 8,
  parameter int KERNEL_WORDS = 8,
  localparam int AW = $clog2(WORDS),
  localparam int PW = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  arr_op_e       op,
  input  logic [AW-1:0] op_addr,
  input  logic [15:0]   op_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  input  logic [AW-1:0] scan_addr,
  output logic [15:0]   scan_data
);
  logic [15:0] mem_q [WORDS];
  logic [15:0] mem_d [WORDS];

  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      mem_d[i] = mem_q[i];
      if ((op == ARR_PAGE || op == ARR_PAGE_WRITE) &&
          ((AW'(i) >> PW) == (op_addr >> PW)))
        mem_d[i] = '1;
      if (op == ARR_MASS && i >= KERNEL_WORDS)
        mem_d[i] = '1;
    end
    if (op == ARR_WRITE || op == ARR_PAGE_WRITE)
      mem_d[op_addr] = op_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (op != ARR_NONE) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data   = mem_q[rd_addr];
  assign scan_data = mem_q[scan_addr];

  for (genvar k = 0; k < KERNEL_WORDS; k++) begin : g_kernel_chk
    AST_KERNEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op == ARR_MASS) |=> $stable(mem_q[k])); // R7
  end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic [CNT_W-1:0] elapsed,
  output logic             last
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len_q, len_d;

  assign last    = busy_q && (cnt_q == len_q - 1'b1);
  assign busy    = busy_q;
  assign elapsed = cnt_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = len;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |-> (len != '0)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q)); // R2
endmodule

// File: rtl/fcs_keyguard.sv
module fcs_keyguard
  import fcs_pkg::*;
#(
  parameter logic [15:0] KEY_A = 16'hA5C3,
  parameter logic [15:0] KEY_B = 16'h3C5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        data_sel,
  input  logic [15:0] wdata,
  output logic        armed
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr) begin
      if (data_sel && wdata == KEY_A)                        st_d = K_HALF;
      else if (data_sel && wdata == KEY_B && st_q == K_HALF) st_d = K_ARMED;
      else                                                   st_d = K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == K_ARMED);

  AST_KEY_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == K_ARMED) |-> $past(wr && data_sel && wdata == KEY_B)); // R8
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int          WORDS        = 32,
  parameter int          PAGE_WORDS   = 8,
  parameter int          KERNEL_WORDS = 8,
  parameter int          CNT_W        = 8,
  parameter int          T_READ       = 2,
  parameter int          T_WRITE      = 3,
  parameter int          T_ERWR       = 20,
  parameter int          T_VERIFY     = 2,
  parameter int          T_ERASE      = 10,
  parameter int          T_MASS       = 30,
  parameter int          T_PROT       = 2,
  parameter int          T_PING       = 1,
  parameter logic [15:0] KEY_A        = 16'hA5C3,
  parameter logic [15:0] KEY_B        = 16'h3C5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam int AW    = $clog2(WORDS);
  localparam int PW    = $clog2(PAGE_WORDS);
  localparam int PAGES = WORDS / PAGE_WORDS;

  logic [AW-1:0]    addr_q, addr_d;
  logic [15:0]      data_q, data_d;
  logic [7:0]       mode_q, mode_d;
  logic [2:0]       stat_q, stat_d;
  logic [23:0]      sig_q, sig_d;
  logic [PAGES-1:0] pstage_q, pstage_d, prot_q, prot_d;
  logic             pused_q, pused_d, irq_q, irq_d;
  logic [3:0]       cmd_q, cmd_d;

  logic             busy, last, armed, accept, cmd_wr, open_wr, page_locked;
  logic [CNT_W-1:0] elapsed, base_len;
  logic [15:0]      rd_word, scan_word;
  arr_op_e          arr_op;

  assign cmd_wr      = reg_wr && !busy && (reg_addr == RA_CMD);
  assign open_wr     = reg_wr && !busy;
  assign page_locked = prot_q[addr_q[AW-1:PW]];

  fcs_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(cmd_wr && accept),
    .len(base_len + CNT_W'(mode_q[1:0])),
    .busy(busy), .elapsed(elapsed), .last(last)
  );

  fcs_keyguard #(.KEY_A(KEY_A), .KEY_B(KEY_B)) key_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .data_sel(reg_addr == RA_DATA),
    .wdata(reg_wdata), .armed(armed)
  );

  fcs_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .KERNEL_WORDS(KERNEL_WORDS)) array_i (
    .clk(clk), .rst_n(rst_n), .op(arr_op), .op_addr(addr_q), .op_data(data_q),
    .rd_addr(addr_q), .rd_data(rd_word),
    .scan_addr(elapsed[AW-1:0]), .scan_data(scan_word)
  );

  // command acceptance and length selection
  always_comb begin
    accept   = 1'b0;
    base_len = '0;
    unique case (reg_wdata[3:0])
      OP_READ:   begin accept = 1'b1;                        base_len = CNT_W'(T_READ);   end
      OP_VERIFY: begin accept = 1'b1;                        base_len = CNT_W'(T_VERIFY); end
      OP_PING:   begin accept = 1'b1;                        base_len = CNT_W'(T_PING);   end
      OP_SIGN:   begin accept = 1'b1;                        base_len = CNT_W'(WORDS);    end
      OP_WRITE:  begin accept = mode_q[3] && !page_locked;   base_len = CNT_W'(T_WRITE);  end
      OP_ERWR:   begin accept = mode_q[3] && !page_locked;   base_len = CNT_W'(T_ERWR);   end
      OP_ERASE:  begin accept = mode_q[3] && !page_locked;   base_len = CNT_W'(T_ERASE);  end
      OP_MASS:   begin accept = mode_q[3] && armed;          base_len = CNT_W'(T_MASS);   end
      OP_PROT:   begin accept = !pused_q;                    base_len = CNT_W'(T_PROT);   end
      default:   begin accept = 1'b0;                        base_len = '0;               end
    endcase
  end

  always_comb begin
    arr_op = ARR_NONE;
    if (last) begin
      unique case (cmd_q)
        OP_WRITE: arr_op = ARR_WRITE;
        OP_ERWR:  arr_op = ARR_PAGE_WRITE;
        OP_ERASE: arr_op = ARR_PAGE;
        OP_MASS:  arr_op = ARR_MASS;
        default:  arr_op = ARR_NONE;
      endcase
    end
  end

  // next-state for the register file
  always_comb begin
    addr_d = addr_q;  data_d = data_q;  mode_d = mode_q;  stat_d = stat_q;
    sig_d = sig_q;    pstage_d = pstage_q;  prot_d = prot_q;  pused_d = pused_q;
    cmd_d = cmd_q;
    irq_d = last && mode_q[4];
    if (open_wr) begin
      unique case (reg_addr)
        RA_ADDR: addr_d   = reg_wdata[AW-1:0];
        RA_DATA: data_d   = reg_wdata;
        RA_MODE: mode_d   = reg_wdata[7:0] & MODE_KEEP;
        RA_PROT: pstage_d = reg_wdata[PAGES-1:0];
        default: ;
      endcase
    end
    if (cmd_wr && reg_wdata[3:0] != OP_NULL) begin
      if (accept) begin
        cmd_d  = reg_wdata[3:0];
        stat_d = 3'b000;
        if (reg_wdata[3:0] == OP_SIGN) sig_d = CRC_SEED;
      end else begin
        stat_d = 3'b100;
      end
    end
    if (busy && cmd_q == OP_SIGN && elapsed < CNT_W'(WORDS))
      sig_d = crc24_word(sig_q, scan_word);
    if (last) begin
      stat_d = {1'b0, (cmd_q == OP_VERIFY) && (rd_word == data_q), 1'b1};
      if (cmd_q == OP_READ) data_d = rd_word;
      if (cmd_q == OP_PROT) begin prot_d = pstage_q; pused_d = 1'b1; end
      if (cmd_q == OP_MASS) begin prot_d = '0;       pused_d = 1'b0; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;  data_q <= '0;  mode_q <= '0;  stat_q <= '0;  sig_q <= '0;
      pstage_q <= '0;  prot_q <= '0;  pused_q <= 1'b0;  cmd_q <= OP_NULL;  irq_q <= 1'b0;
    end else begin
      addr_q <= addr_d;  data_q <= data_d;  mode_q <= mode_d;  stat_q <= stat_d;  sig_q <= sig_d;
      pstage_q <= pstage_d;  prot_q <= prot_d;  pused_q <= pused_d;  cmd_q <= cmd_d;  irq_q <= irq_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CMD:   reg_rdata = busy ? BUSY_CODE : 16'h0000;
      RA_ADDR:  reg_rdata = 16'(addr_q);
      RA_DATA:  reg_rdata = data_q;
      RA_MODE:  reg_rdata = {8'h00, mode_q};
      RA_STAT:  reg_rdata = {13'h0000, stat_q};
      RA_SIGLO: reg_rdata = sig_q[15:0];
      RA_SIGHI: reg_rdata = {8'h00, sig_q[23:16]};
      default:  reg_rdata = 16'(prot_q);
    endcase
  end

  assign irq = irq_q;

  AST_NO_CHANGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_op != ARR_NONE) |-> mode_q[3]); // R4
  AST_MODE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~MODE_KEEP) == 8'h00); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R11
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(busy)); // R11
  AST_PROT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pused_q && arr_op != ARR_MASS) |=> $stable(prot_q)); // R10
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;

  localparam logic [15:0] KA = 16'hA5C3;
  localparam logic [15:0] KB = 16'h3C5A;

  always #2 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] shadow [32];

  // {mode, code, addr, data, expected status, expected busy cycles}
  localparam int NV = 16;
  localparam logic [43:0] VEC [NV] = '{
    {8'h08, 4'h2, 5'd9,  16'h1234, 3'b001, 8'd3},
    {8'h09, 4'h2, 5'd10, 16'hBEEF, 3'b001, 8'd4},
    {8'h0B, 4'h4, 5'd9,  16'h1234, 3'b011, 8'd5},
    {8'h08, 4'h4, 5'd9,  16'h0000, 3'b001, 8'd2},
    {8'h00, 4'h2, 5'd11, 16'h5555, 3'b100, 8'd0},
    {8'h00, 4'h5, 5'd9,  16'h0000, 3'b100, 8'd0},
    {8'h08, 4'h3, 5'd12, 16'h0F0F, 3'b001, 8'd20},
    {8'h08, 4'h9, 5'd0,  16'h0000, 3'b100, 8'd0},
    {8'h08, 4'hF, 5'd0,  16'h0000, 3'b001, 8'd1},
    {8'h0A, 4'h6, 5'd0,  16'h0000, 3'b100, 8'd0},
    {8'h08, 4'h2, 5'd3,  16'hAAAA, 3'b001, 8'd3},
    {8'h08, 4'h2, 5'd20, 16'h1357, 3'b001, 8'd3},
    {8'h08, 4'h5, 5'd17, 16'h0000, 3'b001, 8'd10},
    {8'h08, 4'h2, 5'd31, 16'h2468, 3'b001, 8'd3},
    {8'h08, 4'h2, 5'd20, 16'h1357, 3'b001, 8'd3},
    {8'h08, 4'h4, 5'd12, 16'h0F0F, 3'b011, 8'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic run(input logic [3:0] c, output int len, output logic irq_end);
    wr(3'd0, {12'h000, c});
    len = 0;
    while (1) begin
      @(negedge clk);
      reg_addr = 3'd0;
      #1;
      if (reg_rdata == 16'h0007) len++;
      else break;
    end
    irq_end = irq;
  endtask

  task automatic rd_word(input logic [4:0] a, output logic [15:0] v);
    int l; logic i;
    wr(3'd1, {11'h000, a});
    run(4'h1, l, i);
    rd(3'd2, v);
  endtask

  function automatic logic [23:0] model_sig();
    logic [23:0] c = 24'hB704CE;
    for (int a = 0; a < 32; a++) begin
      for (int b = 15; b >= 0; b--) begin
        logic fb;
        fb = c[23] ^ shadow[a][b];
        c = {c[22:0], 1'b0};
        if (fb) c = c ^ 24'h864CFB;
      end
    end
    return c;
  endfunction

  function automatic string req_of(input logic [3:0] c, input logic [2:0] st);
    if (st == 3'b100) begin
      if (c == 4'h6) return "R8";
      if (c inside {4'h7, 4'h8, 4'h9, 4'hA, 4'hD, 4'hE}) return "R12";
      return "R4";
    end
    if (c == 4'h4) return "R6";
    if (c == 4'hF) return "R11";
    return "R5";
  endfunction

  task automatic erase_page(input logic [4:0] a);
    for (int i = 0; i < 8; i++) shadow[{a[4:3], 3'(i)}] = 16'hFFFF;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int len; logic ie; logic [15:0] v, s0, lo, hi;
    for (int i = 0; i < 32; i++) shadow[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 cmd", v, 16'h0000);
    rd(3'd4, v); check("R1 status", v, 16'h0000);
    rd(3'd3, v); check("R1 mode", v, 16'h0000);
    rd(3'd5, v); check("R1 sig", v, 16'h0000);
    check("R1 irq", irq, 1'b0);
    rd_word(5'd0, v);  check("R1 word0", v, 16'hFFFF);
    rd_word(5'd31, v); check("R1 word31", v, 16'hFFFF);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [7:0] m; logic [3:0] c; logic [4:0] a; logic [15:0] d; logic [2:0] st; logic [7:0] ln;
      {m, c, a, d, st, ln} = VEC[k];
      wr(3'd1, {11'h000, a});
      wr(3'd2, d);
      wr(3'd3, {8'h00, m});
      run(c, len, ie);
      check("R2 busy length", len, ln);
      rd(3'd4, v);
      check(req_of(c, st), v, {13'h0000, st});
      if (st[0]) begin
        if (c == 4'h2) shadow[a] = d;
        if (c == 4'h3) begin erase_page(a); shadow[a] = d; end
        if (c == 4'h5) erase_page(a);
      end
    end

    // R5 array contents
    rd_word(5'd9, v);  check("R5 erased by erase-write", v, 16'hFFFF);
    rd_word(5'd12, v); check("R5 erase-write word", v, 16'h0F0F);
    rd_word(5'd3, v);  check("R5 write word3", v, 16'hAAAA);
    rd_word(5'd20, v); check("R5 rewrite after page erase", v, 16'h1357);

    // R9 signature
    wr(3'd3, 16'h0008);
    run(4'hB, len, ie);
    check("R9 sig length", len, 32);
    rd(3'd5, lo); rd(3'd6, hi);
    check("R9 signature", {hi[7:0], lo}, model_sig());

    // R3 mode reserved bits
    wr(3'd3, 16'h00FF);
    rd(3'd3, v); check("R3 mode mask", v, 16'h001B);

    // R11 interrupt
    wr(3'd3, 16'h0018);
    run(4'hF, len, ie); check("R11 irq on ping", ie, 1'b1);
    @(negedge clk); #1 check("R11 irq one cycle", irq, 1'b0);
    wr(3'd3, 16'h0008);
    run(4'hF, len, ie); check("R11 irq disabled", ie, 1'b0);

    // R12 writes ignored while busy
    wr(3'd1, 16'd2); wr(3'd2, 16'h4444);
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h7777); wr(3'd0, 16'h0002); wr(3'd1, 16'd25);
    v = 16'h0007;
    while (v == 16'h0007) rd(3'd0, v);
    erase_page(5'd2); shadow[2] = 16'h4444;
    rd(3'd2, v); check("R12 data kept", v, 16'h4444);
    rd(3'd1, v); check("R12 addr kept", v, 16'h0002);
    rd(3'd4, v); check("R12 status", v, 16'h0001);
    rd_word(5'd25, v); check("R12 busy write dropped", v, shadow[25]);
    rd(3'd4, s0);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R12 null cmd idle", v, 16'h0000);
    rd(3'd4, v); check("R12 null cmd status", v, s0);

    // R10 protection
    wr(3'd7, 16'h0004);
    run(4'hC, len, ie);
    rd(3'd4, v); check("R10 protect ok", v, 16'h0001);
    rd(3'd7, v); check("R10 mask", v, 16'h0004);
    wr(3'd1, 16'd20); wr(3'd2, 16'h1111);
    run(4'h2, len, ie);
    rd(3'd4, v); check("R10 write rejected", v, 16'h0004);
    rd_word(5'd20, v); check("R10 word kept", v, 16'h1357);
    wr(3'd7, 16'h0000);
    run(4'hC, len, ie);
    rd(3'd4, v); check("R10 second protect", v, 16'h0004);
    rd(3'd7, v); check("R10 mask held", v, 16'h0004);
    wr(3'd1, 16'd17);
    run(4'h5, len, ie);
    rd(3'd4, v); check("R10 erase rejected", v, 16'h0004);

    // R8 broken keys
    wr(3'd2, KA); wr(3'd1, 16'd5); wr(3'd2, KB);
    run(4'h6, len, ie);
    rd(3'd4, v); check("R8 split key", v, 16'h0004);
    wr(3'd2, KB); wr(3'd2, KA);
    run(4'h6, len, ie);
    rd(3'd4, v); check("R8 reversed key", v, 16'h0004);

    // R7 keyed mass erase
    wr(3'd2, KA); wr(3'd2, KB);
    run(4'h6, len, ie);
    check("R7 mass length", len, 30);
    rd(3'd4, v); check("R7 mass status", v, 16'h0001);
    for (int i = 8; i < 32; i++) shadow[i] = 16'hFFFF;
    rd(3'd7, v); check("R7 protection cleared", v, 16'h0000);
    rd_word(5'd2, v);  check("R7 kernel kept", v, 16'h4444);
    rd_word(5'd20, v); check("R7 user erased", v, 16'hFFFF);
    run(4'hB, len, ie);
    rd(3'd5, lo); rd(3'd6, hi);
    check("R9 signature after mass erase", {hi[7:0], lo}, model_sig());
    wr(3'd7, 16'h0001);
    run(4'hC, len, ie);
    rd(3'd4, v); check("R10 protect after mass erase", v, 16'h0001);

    finish_run();
  end
endmodule